// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers ten interrupt requests for a small processor core, masks each one with its own enable bit, sorts them into a high and a low priority class with a per-source priority bit, and hands the single winning request to the core as an interrupt line plus an 8-bit vector address. Six requests are level signals from the core's existing peripherals: three timers, a serial port and two external pins whose own edge or level logic sits outside. Four further external pins come in raw. The block synchronizes them, detects an edge of a fixed polarity on each, and holds the result in a sticky flag.

The core takes an interrupt by pulsing `ack_i` while `irq_o` is high. The block answers in the same cycle with a one-hot acknowledge naming the source it served. It clears that source's edge flag if it has one, and records that a routine of that priority class is now running. A high-priority request may interrupt a running low-priority routine. Nothing interrupts a running high-priority routine. Each `reti_i` pulse ends the innermost running routine. Enable and priority bits are loaded through a small write port. Software can also clear edge flags by writing 0 to them.

Source index order, used by every 10-bit vector on the ports (bit 0 first): 0 ext pin A, 1 timer A, 2 ext pin B, 3 timer B, 4 serial, 5 timer C, 6 edge pin 0, 7 edge pin 1, 8 edge pin 2, 9 edge pin 3. A lower index wins over a higher one.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Among eligible pending sources of the same priority class, the source with the lowest index is presented.
- R2: The vector for index i is 8*i+03h for i in 0..5 and 8*i+13h for i in 6..9, giving 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 43h, 4Bh, 53h and 5Bh.
- R3: A pending enabled source whose priority bit is 1 wins over every source whose priority bit is 0, whatever their indices.
- R4: A source whose enable bit is 0 never causes `irq_o`.
- R5: Edge pins 0 and 2 (flags_o bits 0 and 2) set their flag on a rising edge only. Edge pins 1 and 3 (bits 1 and 3) set their flag on a falling edge only.
- R6: An acknowledge drives `ack_src_o` one-hot at the served index in the same cycle, clears that source's edge flag and drops `irq_o` in the next cycle.
- R7: A flag write clears every flag whose `flag_wdata_i` bit is 0 and leaves flags whose bit is 1 unchanged.
- R8: While a low-priority routine runs, only high-priority sources raise `irq_o`. While a high-priority routine runs, none do.
- R9: `reti_i` ends the running high-priority routine if there is one, and otherwise ends the low-priority routine.
- R10: `vec_o` has held its value for at least one cycle when `irq_o` is high, and it stays unchanged while `irq_o` remains high.
- R11: After reset, `irq_o` is 0, all flags are 0, all enables and priorities are 0, and no routine is marked as running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| leg_req_i | input | 6 | Level requests, source indices 0..5 |
| edge_pin_i | input | 4 | Raw edge pins, source indices 6..9 |
| cfg_we_i | input | 1 | Write strobe for enable or priority bits |
| cfg_sel_i | input | 1 | 0 selects enables, 1 selects priorities |
| cfg_wdata_i | input | 10 | Per-source write data |
| flag_we_i | input | 1 | Edge flag write strobe |
| flag_wdata_i | input | 4 | 0 clears the corresponding flag |
| ack_i | input | 1 | Core takes the presented interrupt |
| reti_i | input | 1 | Core leaves the innermost routine |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 8 | Vector address of the presented source |
| ack_src_o | output | 10 | One-hot served source, valid while ack_i is high |
| flags_o | output | 4 | Edge flags of sources 6..9 |

## Verification
The assertions assume that `ack_i` is raised only while `irq_o` is high, that `ack_i` and `reti_i` never arrive in the same cycle, and that `reti_i` comes only when a routine is marked running. They also assume that the priority bits do not change while a request is being presented. The stimulus keeps to these rules. Acknowledges are issued only after `irq_o` has been observed high, returns follow acknowledges one for one, and configuration writes happen only while nothing is acknowledged.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int SRC_N = 10;
    localparam int LEG_N = 6;
    localparam int EXT_N = SRC_N - LEG_N;
    localparam int IDX_W = $clog2(SRC_N);
    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] LEG_BASE = 8'h03;
    localparam logic [VEC_W-1:0] EXT_BASE = 8'h43;
    localparam int VEC_STEP = 8;
    // 1 = rising-edge source, 0 = falling-edge source
    localparam logic [EXT_N-1:0] EXT_RISE = 4'b0101;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] step;
        step = VEC_W'(idx) * VEC_W'(VEC_STEP);
        if (int'(idx) < LEG_N) return LEG_BASE + step;
        return EXT_BASE + step - VEC_W'(LEG_N * VEC_STEP);
    endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N = 4,
    parameter logic [N-1:0] RISE = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] edge_o
);
    typedef struct packed {
        logic [N-1:0] s0;
        logic [N-1:0] s1;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s0   = pin_i;
        st_d.s1   = st_q.s0;
        st_d.prev = st_q.s1;
    end

    for (genvar g = 0; g < N; g++) begin : g_pol
        if (RISE[g]) begin : g_rise
            assign edge_o[g] = st_q.s1[g] & ~st_q.prev[g];
        end else begin : g_fall
            assign edge_o[g] = ~st_q.s1[g] & st_q.prev[g];
        end
    end

    // flops reset to the idle level of each pin
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{s0: ~RISE, s1: ~RISE, prev: ~RISE};
        else         st_q <= st_d;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
(
    input  logic [SRC_N-1:0] pend_i,
    input  logic [SRC_N-1:0] hi_i,
    input  logic             allow_hi_i,
    input  logic             allow_lo_i,
    output pick_t            pick_o
);
    logic [SRC_N-1:0] hi_set, lo_set, cand;

    always_comb begin
        hi_set = pend_i & hi_i & {SRC_N{allow_hi_i}};
        lo_set = pend_i & ~hi_i & {SRC_N{allow_lo_i}};
        cand   = (|hi_set) ? hi_set : lo_set;
        pick_o = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (cand[i]) pick_o.idx = IDX_W'(i);
        end
        pick_o.vld = |cand;
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LEG_N-1:0] leg_req_i,
    input  logic [EXT_N-1:0] edge_pin_i,
    input  logic             cfg_we_i,
    input  logic             cfg_sel_i,
    input  logic [SRC_N-1:0] cfg_wdata_i,
    input  logic             flag_we_i,
    input  logic [EXT_N-1:0] flag_wdata_i,
    input  logic             ack_i,
    input  logic             reti_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [SRC_N-1:0] ack_src_o,
    output logic [EXT_N-1:0] flags_o
);
    typedef struct packed {
        logic [SRC_N-1:0] en;
        logic [SRC_N-1:0] pr;
        logic [EXT_N-1:0] flg;
        logic             run_hi;
        logic             run_lo;
        pick_t            sel;
        logic [VEC_W-1:0] vec;
        logic             irq;
    } state_t;

    state_t st_d, st_q;
    logic [EXT_N-1:0] edge_w;
    logic [SRC_N-1:0] pend_w;
    pick_t            pick_w;
    logic             take_w;
    logic [EXT_N-1:0] clr_w;

    irq_edge_sync #(.N(EXT_N), .RISE(EXT_RISE)) i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (edge_pin_i),
        .edge_o (edge_w)
    );

    assign pend_w = {st_q.flg, leg_req_i} & st_q.en;

    irq_pick i_pick (
        .pend_i     (pend_w),
        .hi_i       (st_q.pr),
        .allow_hi_i (!st_q.run_hi),
        .allow_lo_i (!st_q.run_hi && !st_q.run_lo),
        .pick_o     (pick_w)
    );

    always_comb begin
        st_d   = st_q;
        take_w = ack_i && st_q.irq;
        ack_src_o = take_w ? (SRC_N'(1) << st_q.sel.idx) : '0;

        if (cfg_we_i) begin
            if (cfg_sel_i) st_d.pr = cfg_wdata_i;
            else           st_d.en = cfg_wdata_i;
        end

        // flags: a new edge wins over any clear in the same cycle
        clr_w = flag_we_i ? ~flag_wdata_i : '0;
        if (take_w && int'(st_q.sel.idx) >= LEG_N)
            clr_w = clr_w | (EXT_N'(1) << (st_q.sel.idx - IDX_W'(LEG_N)));
        st_d.flg = (st_q.flg & ~clr_w) | edge_w;

        if (reti_i) begin
            if (st_q.run_hi) st_d.run_hi = 1'b0;
            else             st_d.run_lo = 1'b0;
        end
        if (take_w) begin
            if (st_q.pr[st_q.sel.idx]) st_d.run_hi = 1'b1;
            else                       st_d.run_lo = 1'b1;
        end

        // request only after the same pick has been held for one cycle
        st_d.sel = take_w ? '0 : pick_w;
        st_d.vec = vec_of(pick_w.idx);
        st_d.irq = !take_w && pick_w.vld && st_q.sel.vld && (pick_w.idx == st_q.sel.idx);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o   = st_q.irq;
    assign vec_o   = st_q.vec;
    assign flags_o = st_q.flg;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             irq_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [SRC_N-1:0] ack_src_o,
    input logic [EXT_N-1:0] flags_o,
    input logic             flag_we_i,
    input logic [EXT_N-1:0] flag_wdata_i,
    input logic             ack_i,
    input logic             reti_i,
    input logic             run_hi,
    input logic             run_lo
);
    a_r10_vec_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $stable(vec_o));

    a_r6_ack_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ack_src_o) |=> !irq_o);

    a_r8_none_in_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_hi |-> !irq_o);

    a_r9_pop_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reti_i && !ack_i && run_hi) |=> !run_hi);

    a_r9_pop_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reti_i && !ack_i && !run_hi) |=> !run_lo);

    a_r7_keep_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_we_i && !ack_i) |=>
            ((flags_o & $past(flags_o & flag_wdata_i)) == $past(flags_o & flag_wdata_i)));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_o        (irq_o),
    .vec_o        (vec_o),
    .ack_src_o    (ack_src_o),
    .flags_o      (flags_o),
    .flag_we_i    (flag_we_i),
    .flag_wdata_i (flag_wdata_i),
    .ack_i        (ack_i),
    .reti_i       (reti_i),
    .run_hi       (st_q.run_hi),
    .run_lo       (st_q.run_lo)
);

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic [5:0] leg_req = '0;
    logic [3:0] pin = 4'b1010;
    logic       cfg_we = 0, cfg_sel = 0;
    logic [9:0] cfg_wdata = '0;
    logic       flag_we = 0;
    logic [3:0] flag_wdata = '0;
    logic       ack = 0, reti = 0;
    logic       irq;
    logic [7:0] vec;
    logic [9:0] ack_src;
    logic [3:0] flags;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_vec_ctrl i_irq_vec_ctrl (
        .clk_i(clk), .rst_ni(rst_ni), .leg_req_i(leg_req), .edge_pin_i(pin),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .flag_we_i(flag_we), .flag_wdata_i(flag_wdata), .ack_i(ack), .reti_i(reti),
        .irq_o(irq), .vec_o(vec), .ack_src_o(ack_src), .flags_o(flags)
    );

    // row: en[34:25] pr[24:15] req[14:9] irq[8] vec[7:0]
    localparam logic [34:0] ROWS [10] = '{
        {10'h3FF, 10'h000, 6'b111111, 1'b1, 8'h03},  // R1 R2
        {10'h3FF, 10'h000, 6'b000010, 1'b1, 8'h0B},  // R2
        {10'h3FF, 10'h000, 6'b110000, 1'b1, 8'h23},  // R1
        {10'h3FF, 10'h000, 6'b100000, 1'b1, 8'h2B},  // R2
        {10'h3FF, 10'h008, 6'b001100, 1'b1, 8'h1B},  // R3
        {10'h3FB, 10'h000, 6'b001100, 1'b1, 8'h1B},  // R4
        {10'h000, 10'h000, 6'b000101, 1'b0, 8'h00},  // R4
        {10'h3FF, 10'h020, 6'b111111, 1'b1, 8'h2B},  // R3
        {10'h3FF, 10'h000, 6'b000000, 1'b0, 8'h00},  // R4
        {10'h3FF, 10'h010, 6'b011000, 1'b1, 8'h23}   // R3
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input bit sel, input logic [9:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic fwrite(input logic [3:0] d);
        flag_we = 1; flag_wdata = d;
        @(negedge clk);
        flag_we = 0;
    endtask

    task automatic do_ack(input logic [9:0] exp_src, input string req);
        ack = 1; #1;
        chk(ack_src == exp_src, req, ack_src, exp_src);
        @(negedge clk);
        ack = 0;
        chk(irq == 0, req, irq, 0);
    endtask

    task automatic do_reti();
        reti = 1;
        @(negedge clk);
        reti = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev_vec;
        bit seen;
        wait_n(3);
        rst_ni = 1;
        @(negedge clk);
        // R11: reset state and cleared enables
        chk(irq == 0, "R11", irq, 0);
        chk(flags == 0, "R11", flags, 0);
        leg_req = 6'b111111;
        wait_n(6);
        chk(irq == 0, "R11", irq, 0);
        leg_req = '0;

        foreach (ROWS[k]) begin
            cfg(0, ROWS[k][34:25]);
            cfg(1, ROWS[k][24:15]);
            leg_req = ROWS[k][14:9];
            wait_n(5);
            chk(irq == ROWS[k][8], "R1/R3/R4 table irq", irq, ROWS[k][8]);
            if (ROWS[k][8]) chk(vec == ROWS[k][7:0], "R2 table vec", vec, ROWS[k][7:0]);
        end
        leg_req = '0;
        cfg(1, 10'h000);
        wait_n(3);

        // R5: edge polarity, R7: software clear
        pin[0] = 1; wait_n(5);
        chk(flags == 4'b0001, "R5 rise sets", flags, 4'b0001);
        fwrite(4'b1110); wait_n(1);
        chk(flags == 4'b0000, "R7 write 0 clears", flags, 0);
        pin[0] = 0; wait_n(5);
        chk(flags == 4'b0000, "R5 fall ignored", flags, 0);
        pin[1] = 0; wait_n(5);
        chk(flags == 4'b0010, "R5 fall sets", flags, 4'b0010);
        pin[3] = 1; wait_n(5);
        chk(flags == 4'b0010, "R5 rise ignored", flags, 4'b0010);
        fwrite(4'b1111); wait_n(1);
        chk(flags == 4'b0010, "R7 write 1 keeps", flags, 4'b0010);
        wait_n(3);
        chk(irq == 1 && vec == 8'h4B, "R2 ext vector", vec, 8'h4B);
        do_ack(10'b0010000000, "R6 ack one-hot");
        chk(flags == 4'b0000, "R6 flag cleared", flags, 0);
        do_reti();

        // R8 / R9 nesting
        cfg(1, 10'h100);
        pin[3] = 0; wait_n(7);
        chk(irq == 1 && vec == 8'h5B, "R8 low request", vec, 8'h5B);
        do_ack(10'b1000000000, "R6 ack low");
        leg_req = 6'b000001; wait_n(6);
        chk(irq == 0, "R8 low blocked in low", irq, 0);
        pin[2] = 1; wait_n(7);
        chk(irq == 1 && vec == 8'h53, "R8 high preempts", vec, 8'h53);
        do_ack(10'b0100000000, "R6 ack high");
        wait_n(5);
        chk(irq == 0, "R8 nothing in high", irq, 0);
        do_reti(); wait_n(5);
        chk(irq == 0, "R9 low still running", irq, 0);
        do_reti(); wait_n(5);
        chk(irq == 1 && vec == 8'h03, "R9 both released", vec, 8'h03);
        leg_req = '0; cfg(1, 10'h000); wait_n(3);

        // R10: vector held a cycle before the request
        leg_req = 6'b000011; wait_n(5);
        chk(irq == 1 && vec == 8'h03, "R1 lowest index", vec, 8'h03);
        leg_req = 6'b000010;
        prev_vec = vec; seen = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (!seen && irq && vec == 8'h0B) begin
                seen = 1;
                chk(prev_vec == 8'h0B, "R10 vec before irq", prev_vec, 8'h0B);
            end
            prev_vec = vec;
        end
        chk(seen, "R10 switch seen", seen, 1);
        leg_req = '0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule